// File: doc/BRIEF.md
# Debug TAP with Scan-Chain Selection

This block is the test access port of an on-chip debug unit. It runs the usual sixteen-state TAP controller on TCK and TMS. It holds a 5-bit instruction register and a 5-bit chain-select register. It steers TDI and TDO to one of several data paths: a 1-bit bypass register, a 32-bit identification register, the chain-select register itself, or a numbered debug chain. The instruction and the stored chain number together decide which chain is used.

A host first loads the chain-select instruction and shifts in a chain number. It then uses the read-access or write-access instruction to reach that chain. A separate forcing instruction reaches chain 4 directly and leaves the stored number as it was. This lets the host move between chain 4 and the chain it selected without rewriting the select register.

Each debug chain receives its own capture, shift and update enables. When the chain currently selected for access is 4 or 5, an entry into Run-Test/Idle raises a one-cycle execute strobe towards the core. Selecting chain 0 keeps the core quiet. For stand-alone testing, each chain is represented by a small loop-back stub register. The stub returns on capture whatever it latched at its last update.

Top module: `dbg_chain_tap`

## Requirements
- R1: When trst_n is sampled low at a rising TCK edge, the TAP enters Test-Logic-Reset, the instruction becomes identify (code 0x1E), the stored chain number becomes 0, and a data scan shifts out the IDCODE_VAL parameter least significant bit first.
- R2: Five rising edges with TMS high reach Test-Logic-Reset from any state. The next rising edge in that state restores the identify instruction and chain number 0.
- R3: In Capture-IR the instruction shift register loads 5'b00001, so the first five bits shifted out during an IR scan are 1,0,0,0,0.
- R4: The bypass code 0x1F, and any code other than 0x00, 0x02, 0x04, 0x08, 0x0C, 0x1D and 0x1E, select a 1-bit register that captures 0 and delays TDI by one shift.
- R5: Under chain-select (code 0x02) the data path is a 5-bit register that captures 5'h10 and shifts least significant bit first.
- R6: A shifted chain number changes chain_no only at the rising edge that leaves Update-DR, and not while shifting or in Exit1-DR.
- R7: Under force-4 (code 0x1D), chain_no reads 4 and the data path is chain 4; the stored chain number is unchanged and is used again once a read-access or write-access instruction is loaded.
- R8: Under read-access (0x0C) or write-access (0x00), the data path is the stub of the stored chain. Each stub captures the value it latched at its previous update. A chain number of NCHAIN or more falls back to bypass.
- R9: exec_go is high for exactly the first cycle in Run-Test/Idle when the instruction is read-access or write-access and the stored chain is 4 or 5. It stays low while the TAP remains in Idle, and it stays low for chain 0.
- R10: chain_capture, chain_shift and chain_update carry at most one set bit, at the index of the chain being accessed, and only in Capture-DR, Shift-DR and Update-DR respectively.
- R11: tdo changes only on falling TCK edges: the bit at the shift position appears half a cycle after entry to a Shift state and is 0 outside Shift states.
- R12: halt_sel is high while the instruction is stop (0x08), and restart_sel is high while it is resume (0x04).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| trst_n | input | 1 | Active-low test reset, synchronous to TCK |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| chain_no | output | 5 | Chain currently reached (4 under force-4, else the stored number) |
| halt_sel | output | 1 | Stop instruction is loaded |
| restart_sel | output | 1 | Resume instruction is loaded |
| exec_go | output | 1 | One-cycle execute strobe to the core |
| chain_capture | output | NCHAIN | Per-chain capture enable |
| chain_shift | output | NCHAIN | Per-chain shift enable |
| chain_update | output | NCHAIN | Per-chain update enable |

## Verification
Instruction, chain-number and stub updates all land on the rising edge that leaves an Update state, so the bench reads them one nanosecond after the edge that moves the TAP into Run-Test/Idle. The execute strobe is read at that same point, and again one idle cycle later to confirm it does not repeat. Serial output is read one nanosecond after each falling edge, before the following rising edge shifts it. A separate check just after the rising edge that enters Shift-DR confirms that tdo has not yet moved. The per-chain enables follow the TAP state with no register in between, so they are read right after the edge that enters Capture-DR, Shift-DR or Update-DR.

// File: rtl/dbg_tap_pkg.sv
// Shared definitions for the debug TAP: state encoding, register widths,
// instruction codes and the TMS-driven next-state function.
package dbg_tap_pkg;

    localparam int IR_W  = 5;
    localparam int SEL_W = 5;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] INS_EXTEST = 5'h00;
    localparam logic [IR_W-1:0] INS_CHSEL  = 5'h02;
    localparam logic [IR_W-1:0] INS_RESUME = 5'h04;
    localparam logic [IR_W-1:0] INS_STOP   = 5'h08;
    localparam logic [IR_W-1:0] INS_INTEST = 5'h0C;
    localparam logic [IR_W-1:0] INS_FORCE4 = 5'h1D;
    localparam logic [IR_W-1:0] INS_IDCODE = 5'h1E;
    localparam logic [IR_W-1:0] INS_BYPASS = 5'h1F;

    localparam logic [IR_W-1:0]  IR_CAPTURE  = 5'b00001;
    localparam logic [SEL_W-1:0] SEL_CAPTURE = 5'h10;
    localparam logic [SEL_W-1:0] FORCED_CH   = 5'd4;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// TAP controller state register.
// Assumes: tms is stable around the rising clock edge; rst_n is synchronous.
module tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e st
);

    // Advance the controller on every rising edge; reset forces Test-Logic-Reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_RESET;
        else        st <= tap_next(st, tms);
    end

endmodule

// File: rtl/dr_shift.sv
// Generic capture / shift / update register, shifting least significant bit first.
// Assumes: cap and sft are never high together (they come from distinct TAP states).
// clr is a synchronous soft reset with the same effect as rst_n.
module dr_shift #(
    parameter int            W       = 5,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cap,
    input  logic         sft,
    input  logic         upd,
    input  logic         sin,
    input  logic [W-1:0] cap_val,
    output logic         sout,
    output logic [W-1:0] held
);

    logic [W-1:0] sr;

    // Shift stage: parallel load on capture, one bit towards bit 0 on shift.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  sr <= '0;
        else if (cap)       sr <= cap_val;
        else if (sft)       sr <= (sr >> 1) | (W'(sin) << (W - 1));
    end

    // Holding stage: takes the shifted value on update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  held <= RST_VAL;
        else if (upd)       held <= sr;
    end

    assign sout = sr[0];

endmodule

// File: rtl/dbg_chain_tap.sv
// Debug TAP top level: instruction register, chain-select register, bypass and
// identification registers, per-chain enables, loop-back stub chains, the
// execute strobe and a falling-edge TDO stage.
// Assumes: trst_n is synchronous to tck; IDCODE_VAL has bit 0 set.
module dbg_chain_tap
    import dbg_tap_pkg::*;
#(
    parameter int          NCHAIN     = 8,
    parameter int          STUB_W     = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h0A5C_3E91
) (
    input  logic              tck,
    input  logic              tms,
    input  logic              tdi,
    input  logic              trst_n,
    output logic              tdo,
    output logic [SEL_W-1:0]  chain_no,
    output logic              halt_sel,
    output logic              restart_sel,
    output logic              exec_go,
    output logic [NCHAIN-1:0] chain_capture,
    output logic [NCHAIN-1:0] chain_shift,
    output logic [NCHAIN-1:0] chain_update
);

    localparam int ID_W = 32;

    tap_state_e        st;
    logic              in_tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
    logic [IR_W-1:0]   ir_q;
    logic              ir_sout;
    logic [SEL_W-1:0]  chain_q;
    logic              sel_sout;
    logic              is_ext, is_int, is_sel, is_f4, is_id;
    logic              chain_path, stub_hit;
    logic [SEL_W-1:0]  eff_chain;
    logic [NCHAIN-1:0] pick;
    logic [NCHAIN-1:0] stub_sout;
    logic              stub_bit, dr_bit, tdo_nx;
    logic              byp_q;
    logic [ID_W-1:0]   id_sr;
    logic              idle_d;

    tap_fsm u_fsm (.clk(tck), .rst_n(trst_n), .tms(tms), .st(st));

    assign in_tlr = (st == ST_RESET);
    assign cap_dr = (st == ST_CAP_DR);
    assign sh_dr  = (st == ST_SH_DR);
    assign upd_dr = (st == ST_UPD_DR);
    assign cap_ir = (st == ST_CAP_IR);
    assign sh_ir  = (st == ST_SH_IR);
    assign upd_ir = (st == ST_UPD_IR);

    dr_shift #(.W(IR_W), .RST_VAL(INS_IDCODE)) u_ir (
        .clk(tck), .rst_n(trst_n), .clr(in_tlr),
        .cap(cap_ir), .sft(sh_ir), .upd(upd_ir), .sin(tdi),
        .cap_val(IR_CAPTURE), .sout(ir_sout), .held(ir_q)
    );

    assign is_ext      = (ir_q == INS_EXTEST);
    assign is_int      = (ir_q == INS_INTEST);
    assign is_sel      = (ir_q == INS_CHSEL);
    assign is_f4       = (ir_q == INS_FORCE4);
    assign is_id       = (ir_q == INS_IDCODE);
    assign halt_sel    = (ir_q == INS_STOP);
    assign restart_sel = (ir_q == INS_RESUME);

    dr_shift #(.W(SEL_W), .RST_VAL('0)) u_chsel (
        .clk(tck), .rst_n(trst_n), .clr(in_tlr),
        .cap(cap_dr && is_sel), .sft(sh_dr && is_sel), .upd(upd_dr && is_sel),
        .sin(tdi), .cap_val(SEL_CAPTURE), .sout(sel_sout), .held(chain_q)
    );

    assign chain_path = is_ext || is_int || is_f4;
    assign eff_chain  = is_f4 ? FORCED_CH : chain_q;
    assign chain_no   = eff_chain;
    assign stub_hit   = chain_path && (int'(eff_chain) < NCHAIN);

    for (genvar i = 0; i < NCHAIN; i++) begin : g_chain
        logic [STUB_W-1:0] stub_held;

        assign pick[i]          = stub_hit && (eff_chain == SEL_W'(i));
        assign chain_capture[i] = cap_dr && pick[i];
        assign chain_shift[i]   = sh_dr  && pick[i];
        assign chain_update[i]  = upd_dr && pick[i];

        dr_shift #(.W(STUB_W), .RST_VAL('0)) u_stub (
            .clk(tck), .rst_n(trst_n), .clr(1'b0),
            .cap(chain_capture[i]), .sft(chain_shift[i]), .upd(chain_update[i]),
            .sin(tdi), .cap_val(stub_held), .sout(stub_sout[i]), .held(stub_held)
        );
    end

    // Pick the serial output of the chain being accessed.
    always_comb begin
        stub_bit = 1'b0;
        for (int i = 0; i < NCHAIN; i++) begin
            if (pick[i]) stub_bit = stub_sout[i];
        end
    end

    // Bypass bit: captures 0, then passes TDI through one stage.
    always_ff @(posedge tck) begin
        if (!trst_n)    byp_q <= 1'b0;
        else if (cap_dr) byp_q <= 1'b0;
        else if (sh_dr)  byp_q <= tdi;
    end

    // Identification register: loads the fixed value, then shifts it out.
    always_ff @(posedge tck) begin
        if (!trst_n)              id_sr <= '0;
        else if (cap_dr && is_id) id_sr <= IDCODE_VAL;
        else if (sh_dr && is_id)  id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Data-path selection by instruction and chain number.
    always_comb begin
        if (is_sel)        dr_bit = sel_sout;
        else if (is_id)    dr_bit = id_sr[0];
        else if (stub_hit) dr_bit = stub_bit;
        else               dr_bit = byp_q;
    end

    assign tdo_nx = sh_ir ? ir_sout : (sh_dr ? dr_bit : 1'b0);

    // Output stage: tdo moves on the falling edge only.
    always_ff @(negedge tck) begin
        if (!trst_n) tdo <= 1'b0;
        else         tdo <= tdo_nx;
    end

    // Remember whether the previous cycle was already in Run-Test/Idle.
    always_ff @(posedge tck) begin
        if (!trst_n) idle_d <= 1'b0;
        else         idle_d <= (st == ST_IDLE);
    end

    assign exec_go = (st == ST_IDLE) && !idle_d && (is_int || is_ext)
                     && (chain_q == 5'd4 || chain_q == 5'd5);

endmodule

// File: rtl/dbg_chain_tap_chk.sv
// Property checker for dbg_chain_tap, attached with bind.
// Assumes: the bound signals are sampled at the rising edge of tck.
module dbg_chain_tap_chk
    import dbg_tap_pkg::*;
#(
    parameter int NCHAIN = 8
) (
    input logic              tck,
    input logic              trst_n,
    input tap_state_e        st,
    input logic [IR_W-1:0]   ir_q,
    input logic [SEL_W-1:0]  chain_q,
    input logic [SEL_W-1:0]  chain_no,
    input logic              exec_go,
    input logic [NCHAIN-1:0] chain_capture,
    input logic [NCHAIN-1:0] chain_shift,
    input logic [NCHAIN-1:0] chain_update
);

    assert_reset_state_R1: assert property (@(posedge tck) disable iff (!trst_n)
        $past(!trst_n) |-> (st == ST_RESET && ir_q == INS_IDCODE && chain_q == '0));

    assert_tlr_clears_R2: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(st) == ST_RESET) |-> (ir_q == INS_IDCODE && chain_q == '0));

    assert_chain_moves_on_update_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(chain_q) |-> ($past(st) == ST_UPD_DR || $past(st) == ST_RESET || $past(!trst_n)));

    assert_force4_reads_four_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_q == INS_FORCE4) |-> (chain_no == 5'd4));

    assert_force4_keeps_number_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_q == INS_FORCE4 && $past(ir_q) == INS_FORCE4) |-> $stable(chain_q));

    assert_exec_single_R9: assert property (@(posedge tck) disable iff (!trst_n)
        exec_go |=> !exec_go);

    assert_exec_on_idle_entry_R9: assert property (@(posedge tck) disable iff (!trst_n)
        exec_go |-> (st == ST_IDLE && $past(st) != ST_IDLE && (chain_no == 5'd4 || chain_no == 5'd5)));

    assert_enables_onehot_R10: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0(chain_shift) && $onehot0(chain_capture) && $onehot0(chain_update));

    assert_shift_in_state_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (|chain_shift) |-> (st == ST_SH_DR));

endmodule

bind dbg_chain_tap dbg_chain_tap_chk #(.NCHAIN(NCHAIN)) u_chk (
    .tck(tck), .trst_n(trst_n), .st(st), .ir_q(ir_q), .chain_q(chain_q),
    .chain_no(chain_no), .exec_go(exec_go), .chain_capture(chain_capture),
    .chain_shift(chain_shift), .chain_update(chain_update)
);

// File: tb/test_dbg_chain_tap.sv
`timescale 1ns/1ps
module test_dbg_chain_tap;
    import dbg_tap_pkg::*;

    localparam int          NCH = 8;
    localparam logic [31:0] IDC = 32'h0A5C_3E91;

    logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
    logic tdo, halt_sel, restart_sel, exec_go;
    logic [4:0] chain_no;
    logic [NCH-1:0] chain_capture, chain_shift, chain_update;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    dbg_chain_tap #(.NCHAIN(NCH), .STUB_W(8), .IDCODE_VAL(IDC)) i_dbg_chain_tap (
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo),
        .chain_no(chain_no), .halt_sel(halt_sel), .restart_sel(restart_sel),
        .exec_go(exec_go), .chain_capture(chain_capture),
        .chain_shift(chain_shift), .chain_update(chain_update)
    );

    always #5 tck = ~tck;

    typedef struct packed {
        logic [4:0]  ir;
        logic [5:0]  len;
        logic [31:0] din;
        logic [31:0] dout;
        logic [4:0]  chain;
        logic        exe;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{INS_IDCODE, 6'd32, 32'h0,  IDC,      5'd0, 1'b0},
        '{INS_BYPASS, 6'd4,  32'hB,  32'h6,    5'd0, 1'b0},
        '{5'h15,      6'd4,  32'h5,  32'hA,    5'd0, 1'b0},
        '{INS_CHSEL,  6'd5,  32'h5,  32'h10,   5'd5, 1'b0},
        '{INS_EXTEST, 6'd8,  32'hA7, 32'h00,   5'd5, 1'b1},
        '{INS_INTEST, 6'd8,  32'h3C, 32'hA7,   5'd5, 1'b1},
        '{INS_CHSEL,  6'd5,  32'h2,  32'h10,   5'd2, 1'b0},
        '{INS_EXTEST, 6'd8,  32'h5A, 32'h00,   5'd2, 1'b0},
        '{INS_FORCE4, 6'd8,  32'h81, 32'h00,   5'd4, 1'b0},
        '{INS_INTEST, 6'd8,  32'h00, 32'h5A,   5'd2, 1'b0},
        '{INS_FORCE4, 6'd8,  32'h66, 32'h81,   5'd4, 1'b0},
        '{INS_CHSEL,  6'd5,  32'h9,  32'h10,   5'd9, 1'b0},
        '{INS_INTEST, 6'd4,  32'hC,  32'h8,    5'd9, 1'b0},
        '{INS_CHSEL,  6'd5,  32'h4,  32'h10,   5'd4, 1'b0},
        '{INS_INTEST, 6'd8,  32'h00, 32'h66,   5'd4, 1'b1},
        '{INS_CHSEL,  6'd5,  32'h0,  32'h10,   5'd0, 1'b0},
        '{INS_EXTEST, 6'd8,  32'h11, 32'h00,   5'd0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // One TCK cycle: read tdo after the falling edge, drive tms/tdi, pass the rising edge.
    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
    endtask

    task automatic scan_ir(input logic [4:0] code);
        logic o;
        logic [4:0] cap;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 5; i++) begin
            tick(i == 4, code[i], o);
            cap[i] = o;
        end
        check("R3 IR capture pattern", 32'(cap), 32'h01);
        tick(1, 0, o); tick(0, 0, o);
    endtask

    task automatic scan_dr(input int len, input logic [31:0] din, output logic [31:0] got);
        logic o;
        got = '0;
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], o);
            got[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        logic o;
        logic [31:0] got;

        repeat (3) @(posedge tck);
        @(negedge tck);
        trst_n = 1'b1;
        tick(0, 0, o);

        // Reset state (R1, R9, R12)
        check("R1 chain_no after reset", 32'(chain_no), 0);
        check("R9 exec_go after reset", 32'(exec_go), 0);
        check("R12 halt/restart after reset", {30'b0, halt_sel, restart_sel}, 0);
        scan_dr(32, 32'h0, got);
        check("R1 identify after reset", got, IDC);

        // Vector table (R4, R5, R7, R8, R9)
        for (int k = 0; k < NV; k++) begin
            scan_ir(VEC[k].ir);
            scan_dr(int'(VEC[k].len), VEC[k].din, got);
            check($sformatf("R4/R5/R8 data out, vector %0d", k), got, VEC[k].dout);
            check($sformatf("R7/R8 chain_no, vector %0d", k), 32'(chain_no), 32'(VEC[k].chain));
            check($sformatf("R9 exec_go, vector %0d", k), 32'(exec_go), 32'(VEC[k].exe));
            if (VEC[k].exe) begin
                tick(0, 0, o);
                check($sformatf("R9 no repeat in idle, vector %0d", k), 32'(exec_go), 0);
            end
        end

        // Enables and falling-edge output on chain 0 holding 0x11 (R9, R10, R11)
        scan_ir(INS_INTEST);
        tick(1, 0, o);
        tick(0, 0, o);
        check("R10 capture enable", 32'(chain_capture), 32'h01);
        tick(0, 0, o);
        check("R10 shift enable", 32'(chain_shift), 32'h01);
        check("R11 tdo unchanged at rising edge", 32'(tdo), 0);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            tick(i == 7, 1'b0, o);
            got[i] = o;
        end
        check("R11 first bit after falling edge", 32'(got[0]), 1);
        check("R8 chain 0 readback", got, 32'h11);
        tick(1, 0, o);
        check("R10 update enable", 32'(chain_update), 32'h01);
        tick(0, 0, o);
        check("R9 chain 0 suppresses exec", 32'(exec_go), 0);

        // Decoded instruction levels (R12)
        scan_ir(INS_STOP);
        check("R12 stop decode", {30'b0, halt_sel, restart_sel}, 32'h2);
        scan_ir(INS_RESUME);
        check("R12 resume decode", {30'b0, halt_sel, restart_sel}, 32'h1);

        // Chain number changes only after Update-DR (R6)
        scan_ir(INS_CHSEL);
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 5; i++) tick(i == 4, (i < 2), o);
        check("R6 unchanged in Exit1-DR", 32'(chain_no), 0);
        tick(1, 0, o);
        check("R6 unchanged on entering Update-DR", 32'(chain_no), 0);
        tick(0, 0, o);
        check("R6 new number after Update-DR", 32'(chain_no), 3);

        // TMS-high reset path (R2)
        scan_dr(5, 32'h5, got);
        check("R5 capture before TMS reset", got, 32'h10);
        scan_ir(INS_FORCE4);
        check("R7 forced chain", 32'(chain_no), 4);
        for (int i = 0; i < 5; i++) tick(1, 0, o);
        tick(0, 0, o);
        check("R2 chain_no after TMS reset", 32'(chain_no), 0);
        scan_dr(32, 32'h0, got);
        check("R2 identify after TMS reset", got, IDC);

        finished = 1;
        report();
    end

endmodule